// File: doc/BRIEF.md
# Frame-Sync Serial Converter Port

This block is the digital face of a 16-bit sampling converter as a DSP-style host sees it when the host supplies the serial clock. The host pulls the select line low and gives a frame-sync pulse. On the falling edges that follow, it clocks in a 16-bit command word. At fixed clock counts the block then strobes channel selection, opens an acquisition window, and takes the conversion value from a parallel input port. Next it raises its own frame-sync output. It then sends the 16-bit straight-binary result out most significant bit first. A complete frame is 32 serial clocks. Any further clocks shift out zeros.

The serial clock, the host frame sync, the select line and the serial data input are all oversampled by a faster system clock through a two-stage synchroniser, so every state change happens in the system clock domain. Clock numbering is counted from the falling edge of the host frame sync. "Clock n rise" is the n-th rising edge of the serial clock after that point, and "clock n fall" is the n-th falling edge. A new host frame sync abandons any frame in progress. A rise of the select line during a conversion ends the frame and enters shutdown.

The command word leaves the block as a one-cycle `cmd_valid` pulse that carries `cmd_word`. It has no ready and cannot be back-pressured, because the serial host cannot be stalled. The word stays held until the next capture. On the way in, the value on `conv_data` is taken at the system clock edge that raises `conv_take`, whatever its source is doing. The source must present a stable value at that point.

Top module: `fs_conv_port`

## Requirements
- R1: Command bits are taken from `host_sdi` at clock falls 1 to 16; the bit at clock fall 1 lands in bit 15 of `cmd_word`. After clock fall 16, `cmd_valid` pulses for exactly one system clock with the new word, and `cmd_word` does not change at any other time.
- R2: At clock fall 3, `chan_strobe` pulses for one system clock and `acq_active` goes high.
- R3: At clock rise 15, `acq_active` goes low and `conv_take` pulses for one system clock. The value on `conv_data` at that edge becomes the result. Changes to `conv_data` before or after that edge have no effect on the result.
- R4: `dev_fs` is high from clock rise 16 until clock rise 17, and low at all other times.
- R5: From clock rise k, for k from 17 to 32, `sdo` carries result bit 32-k, most significant bit first. Before clock rise 17 in a frame, `sdo` is 0.
- R6: From clock rise 33 until the next host frame sync, `sdo` is 0.
- R7: A rise of `host_fs` while `sel_n` is low abandons the frame in progress. `acq_active` drops, no `cmd_valid` is produced for the abandoned frame, and counting restarts at the following fall of `host_fs`.
- R8: A rise of `sel_n` during a conversion sets `shutdown` and ends the frame, with `acq_active` low. A conversion runs from the fall of `host_fs` through clock rise 32. A rise of `sel_n` after a completed frame leaves `shutdown` at 0.
- R9: `sdo_oe` is the inverse of `sel_n` after synchronisation. While `sel_n` is high, host frame syncs and serial clocks have no effect.
- R10: `shutdown` stays set until a rise of `host_fs` with `sel_n` low clears it.
- R11: After reset, `sdo`, `dev_fs`, `acq_active`, `chan_strobe`, `conv_take`, `cmd_valid`, `shutdown` and `cmd_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| host_fs | input | 1 | Host frame-sync pulse |
| sel_n | input | 1 | Active-low select; a rise mid-conversion means shutdown |
| host_sdi | input | 1 | Serial command data from the host |
| conv_data | input | 16 | Parallel conversion value to be sent |
| conv_take | output | 1 | One-cycle pulse; `conv_data` taken at this edge |
| cmd_word | output | 16 | Last captured command word |
| cmd_valid | output | 1 | One-cycle pulse when `cmd_word` is new |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Output enable for `sdo` (low means tri-state) |
| dev_fs | output | 1 | Device frame-sync output ahead of result data |
| acq_active | output | 1 | Acquisition window open |
| chan_strobe | output | 1 | One-cycle channel-selection strobe |
| shutdown | output | 1 | Shutdown status |

## Verification
On every cycle the assertions check the following. The sample and command strobes are single pulses. The sample strobe never coincides with an open acquisition window, and the channel strobe always does. The device frame sync never overlaps acquisition. The command word moves only with its valid pulse. Shutdown entry always goes with a disabled output. The bench scenarios show what depends on clock counts: which edge each strobe lands on, the bit order of capture and of the result, the zero fill after 32 clocks, restart after an abandoned frame, and the rules for entering and leaving shutdown.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef struct packed {
    logic sclk;
    logic fs;
    logic sel;
    logic sdi;
  } pins_t;
endpackage

// File: rtl/fsp_sync.sv
module fsp_sync
  import fsp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t d,
  output pins_t q,
  output pins_t q_prev
);
  localparam int W = $bits(pins_t);

  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= '0;
      last <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      last <= stg[STAGES-1];
    end
  end

  assign q      = pins_t'(stg[STAGES-1]);
  assign q_prev = pins_t'(last);
endmodule

// File: rtl/fsp_frame_ctl.sv
module fsp_frame_ctl
  import fsp_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int CHAN_FALL   = 3,
  parameter int SAMPLE_RISE = 15,
  parameter int FSO_RISE    = 16,
  parameter int FRAME_CLKS  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pins_t            cur,
  input  pins_t            prev,
  output logic             clear,
  output logic             start,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic [CNT_W-1:0] rise_k,
  output logic [CNT_W-1:0] fall_k,
  output logic             acq_active,
  output logic             chan_strobe,
  output logic             conv_take,
  output logic             dev_fs,
  output logic             shutdown
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             armed;
  logic [CNT_W-1:0] rise_cnt, fall_cnt;
  logic             sel_rise, fs_rise, fs_fall, in_conv;

  assign sel_rise = cur.sel & ~prev.sel;
  assign fs_rise  = cur.fs & ~prev.fs & ~cur.sel;
  assign fs_fall  = ~cur.fs & prev.fs & ~cur.sel;
  assign clear    = cur.sel | fs_rise;
  assign start    = fs_fall;
  assign rise_ev  = armed & cur.sclk & ~prev.sclk & ~clear & ~start;
  assign fall_ev  = armed & ~cur.sclk & prev.sclk & ~clear & ~start;
  assign rise_k   = (rise_cnt == CNT_MAX) ? rise_cnt : rise_cnt + 1'b1;
  assign fall_k   = (fall_cnt == CNT_MAX) ? fall_cnt : fall_cnt + 1'b1;
  assign in_conv  = armed & (rise_cnt < CNT_W'(FRAME_CLKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      rise_cnt    <= '0;
      fall_cnt    <= '0;
      acq_active  <= 1'b0;
      chan_strobe <= 1'b0;
      conv_take   <= 1'b0;
      dev_fs      <= 1'b0;
      shutdown    <= 1'b0;
    end else begin
      chan_strobe <= 1'b0;
      conv_take   <= 1'b0;
      if (cur.sel) begin
        armed      <= 1'b0;
        acq_active <= 1'b0;
        dev_fs     <= 1'b0;
        if (sel_rise && in_conv) shutdown <= 1'b1;
      end else if (fs_rise) begin
        armed      <= 1'b0;
        acq_active <= 1'b0;
        dev_fs     <= 1'b0;
        shutdown   <= 1'b0;
      end else if (start) begin
        armed    <= 1'b1;
        rise_cnt <= '0;
        fall_cnt <= '0;
      end else begin
        if (rise_ev) begin
          rise_cnt <= rise_k;
          if (rise_k == CNT_W'(SAMPLE_RISE)) begin
            acq_active <= 1'b0;
            conv_take  <= 1'b1;
          end
          if (rise_k == CNT_W'(FSO_RISE))     dev_fs <= 1'b1;
          if (rise_k == CNT_W'(FSO_RISE + 1)) dev_fs <= 1'b0;
        end
        if (fall_ev) begin
          fall_cnt <= fall_k;
          if (fall_k == CNT_W'(CHAN_FALL)) begin
            chan_strobe <= 1'b1;
            acq_active  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fsp_cmd_rx.sv
module fsp_cmd_rx #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fall_ev,
  input  logic [CNT_W-1:0]  fall_k,
  input  logic              sdi,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_valid
);
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] nxt;

  assign nxt = {sr[WORD_W-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      cmd_word  <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (start) begin
        sr <= '0;
      end else if (fall_ev && fall_k <= CNT_W'(WORD_W)) begin
        sr <= nxt;
        if (fall_k == CNT_W'(WORD_W)) begin
          cmd_word  <= nxt;
          cmd_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsp_res_tx.sv
module fsp_res_tx #(
  parameter int WORD_W      = 16,
  parameter int CNT_W       = 6,
  parameter int SAMPLE_RISE = 15,
  parameter int OUT_FIRST   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start,
  input  logic              rise_ev,
  input  logic [CNT_W-1:0]  rise_k,
  input  logic [WORD_W-1:0] conv_data,
  output logic              sdo
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      sdo <= 1'b0;
    end else if (clear || start) begin
      sr  <= '0;
      sdo <= 1'b0;
    end else if (rise_ev) begin
      if (rise_k == CNT_W'(SAMPLE_RISE)) begin
        sr <= conv_data;
      end else if (rise_k >= CNT_W'(OUT_FIRST)) begin
        sdo <= sr[WORD_W-1];
        sr  <= {sr[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/fs_conv_port.sv
module fs_conv_port
  import fsp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CHAN_FALL   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              host_fs,
  input  logic              sel_n,
  input  logic              host_sdi,
  input  logic [WORD_W-1:0] conv_data,
  output logic              conv_take,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_valid,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              dev_fs,
  output logic              acq_active,
  output logic              chan_strobe,
  output logic              shutdown
);
  localparam int SAMPLE_RISE = WORD_W - 1;
  localparam int FSO_RISE    = WORD_W;
  localparam int OUT_FIRST   = WORD_W + 1;
  localparam int FRAME_CLKS  = 2 * WORD_W;
  localparam int CNT_W       = $clog2(FRAME_CLKS + 4);

  pins_t            raw, cur, prev;
  logic             clear, start, rise_ev, fall_ev;
  logic [CNT_W-1:0] rise_k, fall_k;

  assign raw = '{sclk: sclk, fs: host_fs, sel: sel_n, sdi: host_sdi};

  fsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(cur), .q_prev(prev)
  );

  fsp_frame_ctl #(
    .CNT_W(CNT_W), .CHAN_FALL(CHAN_FALL), .SAMPLE_RISE(SAMPLE_RISE),
    .FSO_RISE(FSO_RISE), .FRAME_CLKS(FRAME_CLKS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev),
    .clear(clear), .start(start), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .rise_k(rise_k), .fall_k(fall_k), .acq_active(acq_active),
    .chan_strobe(chan_strobe), .conv_take(conv_take), .dev_fs(dev_fs),
    .shutdown(shutdown)
  );

  fsp_cmd_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .fall_ev(fall_ev),
    .fall_k(fall_k), .sdi(cur.sdi), .cmd_word(cmd_word), .cmd_valid(cmd_valid)
  );

  fsp_res_tx #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .SAMPLE_RISE(SAMPLE_RISE), .OUT_FIRST(OUT_FIRST)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start), .rise_ev(rise_ev),
    .rise_k(rise_k), .conv_data(conv_data), .sdo(sdo)
  );

  assign sdo_oe = ~cur.sel;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_take,
  input logic [WORD_W-1:0] cmd_word,
  input logic              cmd_valid,
  input logic              sdo_oe,
  input logic              dev_fs,
  input logic              acq_active,
  input logic              chan_strobe,
  input logic              shutdown
);
  p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_word));
  p_chan_opens_acq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_strobe |-> acq_active);
  p_take_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_take |=> !conv_take);
  p_take_closes_acq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_take |-> !acq_active);
  p_fso_outside_acq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_fs |-> !acq_active);
  p_shdn_disables_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> !sdo_oe);
endmodule

bind fs_conv_port fsp_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_take(conv_take), .cmd_word(cmd_word),
  .cmd_valid(cmd_valid), .sdo_oe(sdo_oe), .dev_fs(dev_fs),
  .acq_active(acq_active), .chan_strobe(chan_strobe), .shutdown(shutdown)
);

// File: tb/fs_conv_port_bench.sv
`timescale 1ns/1ps
module fs_conv_port_bench;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, host_fs = 1'b0, sel_n = 1'b1, host_sdi = 1'b0;
  logic [15:0] conv_data = '0;
  logic        conv_take, cmd_valid, sdo, sdo_oe, dev_fs, acq_active, chan_strobe, shutdown;
  logic [15:0] cmd_word;

  int n_chk = 0, n_fail = 0;
  int cur_k = 0;
  int chan_n = 0, take_n = 0, valid_n = 0;
  int chan_k = 0, take_k = 0, valid_k = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fs_conv_port u_fs_conv_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .host_fs(host_fs), .sel_n(sel_n),
    .host_sdi(host_sdi), .conv_data(conv_data), .conv_take(conv_take),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid), .sdo(sdo), .sdo_oe(sdo_oe),
    .dev_fs(dev_fs), .acq_active(acq_active), .chan_strobe(chan_strobe),
    .shutdown(shutdown)
  );

  always @(posedge clk) begin
    if (chan_strobe) begin chan_n <= chan_n + 1; chan_k <= cur_k; end
    if (conv_take)   begin take_n <= take_n + 1; take_k <= cur_k; end
    if (cmd_valid)   begin valid_n <= valid_n + 1; valid_k <= cur_k; end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h (clock %0d)", tag, got, exp, cur_k);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // run: 1 when the frame is expected to proceed (select low)
  task automatic frame(input logic [15:0] cmd, input logic [15:0] val,
                       input int nclk, input bit run);
    int c0 = chan_n, t0 = take_n, v0 = valid_n;
    conv_data = ~val;
    host_fs = 1'b1; cur_k = 0;
    wt(2 * H);
    host_fs = 1'b0;
    wt(H);
    for (int k = 1; k <= nclk; k++) begin
      cur_k = k;
      sclk = 1'b1;
      host_sdi = (k <= 16) ? cmd[16-k] : 1'b0;
      if (k == 16) conv_data = val ^ 16'h5A5A;
      wt(H - 1);
      chk("R4 dev_fs", dev_fs, run && k == 16);
      chk((k <= 3) ? "R2 acq" : "R3 acq", acq_active, run && k >= 4 && k <= 14);
      if (k > 32) chk("R6 zero fill", sdo, 0);
      else        chk("R5 sdo", sdo, (run && k >= 17) ? int'(val[32-k]) : 0);
      wt(1);
      sclk = 1'b0;
      if (k == 14) conv_data = val;
      wt(H);
    end
    if (run && nclk >= 36) begin
      chk("R2 chan count", chan_n - c0, 1);
      chk("R2 chan clock", chan_k, 3);
      chk("R3 take count", take_n - t0, 1);
      chk("R3 take clock", take_k, 15);
      chk("R1 valid count", valid_n - v0, 1);
      chk("R1 valid clock", valid_k, 16);
      chk("R1 cmd word", cmd_word, cmd);
    end
  endtask

  initial begin
    int v0;
    wt(10);
    rst_n = 1'b1;
    wt(5);
    chk("R11 sdo", sdo, 0);
    chk("R11 dev_fs", dev_fs, 0);
    chk("R11 acq", acq_active, 0);
    chk("R11 shutdown", shutdown, 0);
    chk("R11 cmd_valid", cmd_valid, 0);
    chk("R11 cmd_word", cmd_word, 0);
    chk("R11 chan", chan_strobe, 0);
    chk("R11 take", conv_take, 0);
    chk("R9 oe off", sdo_oe, 0);
    sel_n = 1'b0;
    wt(5);
    chk("R9 oe on", sdo_oe, 1);

    // sweep: walking command bits against a computed result pattern
    for (int i = 0; i < 20; i++) begin
      logic [15:0] c, v;
      c = (i < 16) ? (16'h0001 << i) : 16'(i * 16'h3C5B);
      v = 16'(i * 16'h1357) ^ 16'hC3A5;
      frame(c, v, 36, 1'b1);
    end
    frame(16'hFFFF, 16'h0000, 36, 1'b1);
    frame(16'h0000, 16'hFFFF, 36, 1'b1);

    // R7: abandon during acquisition
    frame(16'h1234, 16'hABCD, 10, 1'b1);
    chk("R7 acq before", acq_active, 1);
    v0 = valid_n;
    host_fs = 1'b1;
    wt(6);
    chk("R7 acq dropped", acq_active, 0);
    chk("R7 no valid", valid_n - v0, 0);
    frame(16'hBEEF, 16'h7E81, 36, 1'b1);
    chk("R7 restart word", cmd_word, 16'hBEEF);

    // R7: abandon during result output
    frame(16'h0F0F, 16'hFFFF, 22, 1'b1);
    frame(16'h3001, 16'h8001, 36, 1'b1);

    // R8: select rise mid-conversion
    frame(16'h5555, 16'h1111, 8, 1'b1);
    sel_n = 1'b1;
    wt(6);
    chk("R8 shutdown set", shutdown, 1);
    chk("R8 acq low", acq_active, 0);
    chk("R9 oe low", sdo_oe, 0);
    v0 = valid_n;
    frame(16'hAAAA, 16'h2222, 20, 1'b0);
    chk("R9 ignored valid", valid_n - v0, 0);
    chk("R9 ignored shutdown", shutdown, 1);
    sel_n = 1'b0;
    wt(6);
    chk("R10 held", shutdown, 1);
    host_fs = 1'b1;
    wt(6);
    chk("R10 cleared", shutdown, 0);

    // R8: select rise after a completed frame
    frame(16'hC001, 16'h4242, 36, 1'b1);
    sel_n = 1'b1;
    wt(6);
    chk("R8 no shutdown after frame", shutdown, 0);
    sel_n = 1'b0;
    wt(6);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule